// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Four Compare Channels

This block is a general-purpose timer for a peripheral subsystem. A 16-bit counter climbs from zero to a programmable reload limit and wraps back to zero. It advances only when a zero-based prescaler lets a count tick through. Four compare channels watch the counter. A channel in PWM mode drives a duty-cycle level. A channel in compare mode raises a sticky match flag each time the counter steps onto its compare value. A channel that is switched off freezes its output and raises no flag.

Software reaches the block through a single-cycle write port and a combinational read port. The prescaler always sits behind a shadow copy. The reload limit sits behind a shadow only when reload buffering is switched on in the control word. Both shadows are refreshed by an update event. An update event is either the counter wrapping or a software restart command, so a new period or rate never splits a running cycle.

Top module: `cmp_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, prescaler sub-count, every register, every match flag and every channel output clear to 0.
- R2: With shadow prescaler value P (zero-based), the counter advances once every P+1 clock edges during which the run bit (bit 0 of the control word at address 0) was already set.
- R3: The counter climbs to the active reload limit and, on the next tick after reaching it, returns to 0.
- R4: A prescaler value written at address 1 takes effect only at the next update event (counter wrap or restart command), and never earlier.
- R5: When bit 7 of the control word (reload buffering) is 1, a reload limit written at address 2 waits in a shadow until the next update event. When bit 7 is 0, the written limit applies at once.
- R6: Writing a word with bit 0 set to address 6 is a restart command: the prescaler and reload shadows load the written values, and the counter and prescaler sub-count return to 0 on that edge.
- R7: Clearing the run bit freezes the counter and keeps all settings. After the run bit is set again, the first possible advance is on the edge following the write edge.
- R8: Address 3 reads the live counter. A write to address 3 replaces the counter on that edge and overrides any tick.
- R9: A channel in compare mode sets its flag (bit i at address 5) on the edge where the counter steps onto its compare value. The flag stays set until 1 is written to that bit at address 5. A set on the same edge as a clear wins.
- R10: A channel in PWM mode outputs 1 while the counter is below its compare value and 0 otherwise. So a compare value of 0 gives a constant 0, and a value above the reload limit gives a constant 1.
- R11: Mode field bits [2i+1:2i] at address 4 select 0 = off, 1 = PWM, 2 = compare (3 acts as off). An off channel never sets its flag and holds its last output. A compare-mode channel drives its output to 0.
- R12: The compare values of channels 0 to 3 are at addresses 8 to 11. Every register reads back what was written, with control reading only bits 0 and 7 and address 6 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| pwm_out | output | 4 | Per-channel output level |
| irq_flag | output | 4 | Per-channel sticky match flag |

## Verification
The hardest cases to reach are the ones where a shadow must not yet have taken a new value. Examples are a prescaler rewritten in mid-period, or a buffered reload that is smaller than the current count. The stimulus writes those values while the counter runs. It then counts edges across the old period and the wrap, and shows that the count follows the old settings until the update event and the new ones after it. A flag clear is also placed exactly on the edge where the counter steps onto the compare value, to show that the set wins.

// File: rtl/cmp_timer_pkg.sv
// Package: shared encodings for the compare timer.
// Assumes a 4-bit register address and at most eight channels.
package cmp_timer_pkg;
    typedef enum logic [1:0] {
        CH_OFF = 2'd0,
        CH_PWM = 2'd1,
        CH_OC  = 2'd2,
        CH_RSV = 2'd3
    } ch_mode_e;

    localparam int AW = 4;
    localparam logic [AW-1:0] A_CTRL   = 4'd0;
    localparam logic [AW-1:0] A_PRESC  = 4'd1;
    localparam logic [AW-1:0] A_RELOAD = 4'd2;
    localparam logic [AW-1:0] A_COUNT  = 4'd3;
    localparam logic [AW-1:0] A_MODE   = 4'd4;
    localparam logic [AW-1:0] A_FLAGS  = 4'd5;
    localparam logic [AW-1:0] A_EVENT  = 4'd6;
    localparam logic [AW-1:0] A_CMP0   = 4'd8;

    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_PRELOAD_BIT = 7;
endpackage

// File: rtl/cmp_timer_regs.sv
// Register file: holds software-visible settings and decodes write pulses.
// Assumes one write per cycle; 2*NCH <= W.
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic [W-1:0]            wr_data,
    output logic                    run,
    output logic                    preload,
    output logic [W-1:0]            psc_reg,
    output logic [W-1:0]            arr_reg,
    output logic [2*NCH-1:0]        mode_bits,
    output logic [NCH-1:0][W-1:0]   cmp_q,
    output logic                    cnt_wr,
    output logic                    restart,
    output logic [NCH-1:0]          flag_clr
);
    // Decode single-cycle command pulses from the write port.
    always_comb begin
        cnt_wr   = wr_en && (addr == A_COUNT);
        restart  = wr_en && (addr == A_EVENT) && wr_data[0];
        flag_clr = (wr_en && (addr == A_FLAGS)) ? wr_data[NCH-1:0] : '0;
    end

    // Store the common settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            preload   <= 1'b0;
            psc_reg   <= '0;
            arr_reg   <= '0;
            mode_bits <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    run     <= wr_data[CTRL_RUN_BIT];
                    preload <= wr_data[CTRL_PRELOAD_BIT];
                end
                A_PRESC:  psc_reg   <= wr_data;
                A_RELOAD: arr_reg   <= wr_data;
                A_MODE:   mode_bits <= wr_data[2*NCH-1:0];
                default: ;
            endcase
        end
    end

    // One compare register per channel.
    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_q[i] <= '0;
            else if (wr_en && (int'(addr) == int'(A_CMP0) + i))
                cmp_q[i] <= wr_data;
        end
    end
endmodule

// File: rtl/cmp_timer_base.sv
// Time base: zero-based prescaler, up-counter and the update-event shadows.
// Assumes restart has priority over a counter write, and a counter write over a tick.
module cmp_timer_base #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         preload,
    input  logic [W-1:0] psc_reg,
    input  logic [W-1:0] arr_reg,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         restart,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_next,
    output logic         step
);
    logic [W-1:0] psc_sh, psc_cnt, arr_sh, arr_eff;
    logic         tick, wrap, update;

    // Derive tick, wrap and the next count value.
    always_comb begin
        arr_eff  = preload ? arr_sh : arr_reg;
        tick     = run && (psc_cnt == psc_sh);
        wrap     = (cnt_q == arr_eff);
        step     = tick && !restart && !cnt_wr;
        cnt_next = wrap ? '0 : cnt_q + 1'b1;
        update   = restart || (step && wrap);
    end

    // Prescaler sub-counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                psc_cnt <= '0;
        else if (update || tick)   psc_cnt <= '0;
        else if (run)              psc_cnt <= psc_cnt + 1'b1;
    end

    // Main counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (restart)  cnt_q <= '0;
        else if (cnt_wr)   cnt_q <= cnt_wdata;
        else if (step)     cnt_q <= cnt_next;
    end

    // Shadow registers loaded on update events (reload tracks when unbuffered).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_sh <= '0;
            arr_sh <= '0;
        end else begin
            if (update)              psc_sh <= psc_reg;
            if (update || !preload)  arr_sh <= arr_reg;
        end
    end
endmodule

// File: rtl/cmp_timer_chan.sv
// One compare channel: PWM level, compare-match flag, and hold while off.
// Assumes step/cnt_next come from the time base in the same cycle.
module cmp_timer_chan
    import cmp_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ch_mode_e     mode,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] cnt_next,
    input  logic         step,
    input  logic         clr,
    output logic         out,
    output logic         flag
);
    logic held_q, match_set;

    // Output level by mode; off channels replay the held level.
    always_comb begin
        case (mode)
            CH_PWM:  out = (cnt_q < cmp);
            CH_OC:   out = 1'b0;
            default: out = held_q;
        endcase
        match_set = step && (mode == CH_OC) && (cnt_next == cmp);
    end

    // Remember the last driven level for when the channel is switched off.
    always_ff @(posedge clk) begin
        if (!rst_n)                              held_q <= 1'b0;
        else if (mode == CH_PWM || mode == CH_OC) held_q <= out;
    end

    // Sticky match flag; a new match wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (match_set) flag <= 1'b1;
        else if (clr)       flag <= 1'b0;
    end
endmodule

// File: rtl/cmp_timer.sv
// Top: prescaled up-counting timer with NCH compare channels and a register port.
// Assumes 2*NCH <= W and NCH <= 8 so the map fits a 4-bit address.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [3:0]     addr,
    input  logic [W-1:0]   wr_data,
    output logic [W-1:0]   rd_data,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] irq_flag
);
    logic                  run, preload, cnt_wr, restart, step;
    logic [W-1:0]          psc_reg, arr_reg, cnt_q, cnt_next;
    logic [2*NCH-1:0]      mode_bits;
    logic [NCH-1:0][W-1:0] cmp_q;
    logic [NCH-1:0]        flag_clr;

    cmp_timer_regs #(.W(W), .NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .run(run), .preload(preload), .psc_reg(psc_reg), .arr_reg(arr_reg),
        .mode_bits(mode_bits), .cmp_q(cmp_q), .cnt_wr(cnt_wr),
        .restart(restart), .flag_clr(flag_clr)
    );

    cmp_timer_base #(.W(W)) u_base (
        .clk(clk), .rst_n(rst_n), .run(run), .preload(preload),
        .psc_reg(psc_reg), .arr_reg(arr_reg), .cnt_wr(cnt_wr),
        .cnt_wdata(wr_data), .restart(restart),
        .cnt_q(cnt_q), .cnt_next(cnt_next), .step(step)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cmp_timer_chan #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .mode(ch_mode_e'(mode_bits[2*i +: 2])), .cmp(cmp_q[i]),
            .cnt_q(cnt_q), .cnt_next(cnt_next), .step(step),
            .clr(flag_clr[i]), .out(pwm_out[i]), .flag(irq_flag[i])
        );
    end

    // Read multiplexer over the register map.
    always_comb begin
        rd_data = '0;
        case (addr)
            A_CTRL: begin
                rd_data[CTRL_RUN_BIT]     = run;
                rd_data[CTRL_PRELOAD_BIT] = preload;
            end
            A_PRESC:  rd_data = psc_reg;
            A_RELOAD: rd_data = arr_reg;
            A_COUNT:  rd_data = cnt_q;
            A_MODE:   rd_data[2*NCH-1:0] = mode_bits;
            A_FLAGS:  rd_data[NCH-1:0]   = irq_flag;
            default: begin
                for (int i = 0; i < NCH; i++)
                    if (int'(addr) == int'(A_CMP0) + i) rd_data = cmp_q[i];
            end
        endcase
    end
endmodule

// File: rtl/cmp_timer_chk.sv
// Checker: temporal properties of the compare timer, bound into the top.
module cmp_timer_chk
    import cmp_timer_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             wr_en,
    input logic [3:0]       addr,
    input logic [W-1:0]     wr_data,
    input logic [W-1:0]     cnt_q,
    input logic [2*NCH-1:0] mode_bits,
    input logic [W-1:0]     cmp0,
    input logic [NCH-1:0]   flags,
    input logic [NCH-1:0]   pwm
);
    // R1: reset clears counter and flags
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && flags == '0));

    // R7: paused counter without a write or restart stays put
    a_r7_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && (addr == A_COUNT || (addr == A_EVENT && wr_data[0]))))
        |=> $stable(cnt_q));

    // R9: a flag only falls after a 1 was written to its clear bit
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[0]) |-> $past(wr_en && addr == A_FLAGS && wr_data[0]));

    // R11: a flag only rises while its channel is in compare mode
    a_r11_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> ($past(mode_bits[1:0]) == CH_OC));

    // R10: PWM with a zero compare value stays low
    a_r10_pwm_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits[1:0] == CH_PWM && cmp0 == '0) |-> !pwm[0]);

    // R11: compare-mode channel drives its output low
    a_r11_oc_out_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits[1:0] == CH_OC) |-> !pwm[0]);
endmodule

bind cmp_timer cmp_timer_chk #(.W(W), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .cnt_q(cnt_q), .mode_bits(mode_bits),
    .cmp0(cmp_q[0]), .flags(irq_flag), .pwm(pwm_out)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {prescaler, reload, wait cycles}
    localparam logic [47:0] VEC [0:NVEC-1] = '{
        {16'd0, 16'd9,  16'd7},
        {16'd0, 16'd9,  16'd23},
        {16'd2, 16'd4,  16'd20},
        {16'd3, 16'd15, 16'd50},
        {16'd1, 16'd0,  16'd9},
        {16'd4, 16'd7,  16'd100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic [3:0]  pwm_out, irq_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer i_cmp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out), .irq_flag(irq_flag)
    );

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        addr = a; #1; v = rd_data;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic setup(input logic [15:0] p, input logic [15:0] r, input logic [15:0] ctrl);
        wr(4'd0, 16'd0);
        wr(4'd1, p);
        wr(4'd2, r);
        wr(4'd6, 16'd1);
        wr(4'd0, ctrl);
    endtask

    initial begin
        repeat (CLK_PERIOD * 100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        waitc(3);
        rst_n = 1'b1;
        // R1: reset state
        rdchk("R1 count", 4'd3, 16'd0);
        rdchk("R1 presc", 4'd1, 16'd0);
        chk("R1 flags", {12'd0, irq_flag}, 16'd0);
        chk("R1 pwm", {12'd0, pwm_out}, 16'd0);

        // R2 R3: table of prescaler/reload/wait vectors
        for (int k = 0; k < NVEC; k++) begin
            int p, r, n, e;
            p = int'(VEC[k][47:32]);
            r = int'(VEC[k][31:16]);
            n = int'(VEC[k][15:0]);
            e = (n / (p + 1)) % (r + 1);
            setup(VEC[k][47:32], VEC[k][31:16], 16'h0001);
            waitc(n);
            rdchk($sformatf("R2 R3 vector %0d", k), 4'd3, 16'(e));
        end

        // R4: mid-run prescaler write has no effect until restart
        setup(16'd0, 16'd99, 16'h0001);
        waitc(5);
        wr(4'd1, 16'd3);
        rdchk("R4 after psc write", 4'd3, 16'd6);
        waitc(10);
        rdchk("R4 old rate kept", 4'd3, 16'd16);
        // R6: restart loads new prescaler and zeroes counter
        wr(4'd6, 16'd1);
        rdchk("R6 restart zero", 4'd3, 16'd0);
        waitc(8);
        rdchk("R6 new rate", 4'd3, 16'd2);

        // R4: prescaler applied at rollover
        setup(16'd0, 16'd3, 16'h0001);
        wr(4'd1, 16'd1);
        waitc(3);
        rdchk("R4 wrap reached", 4'd3, 16'd0);
        waitc(4);
        rdchk("R4 rate after wrap", 4'd3, 16'd2);

        // R5: unbuffered reload applies at once
        setup(16'd0, 16'd99, 16'h0001);
        waitc(3);
        wr(4'd2, 16'd5);
        waitc(4);
        rdchk("R5 immediate reload", 4'd3, 16'd2);

        // R5: buffered reload waits for an update
        setup(16'd0, 16'd99, 16'h0081);
        waitc(3);
        wr(4'd2, 16'd5);
        waitc(4);
        rdchk("R5 buffered reload", 4'd3, 16'd8);
        wr(4'd6, 16'd1);
        waitc(8);
        rdchk("R5 buffered applied", 4'd3, 16'd2);
        rdchk("R12 ctrl readback", 4'd0, 16'h0081);
        rdchk("R12 event reads zero", 4'd6, 16'd0);

        // R8: counter write
        setup(16'd0, 16'd99, 16'h0001);
        wr(4'd3, 16'd50);
        rdchk("R8 count write", 4'd3, 16'd50);
        waitc(3);
        rdchk("R8 count continues", 4'd3, 16'd53);

        // R7: pause and resume
        wr(4'd0, 16'd0);
        waitc(10);
        rdchk("R7 paused", 4'd3, 16'd54);
        wr(4'd0, 16'd1);
        rdchk("R7 no advance on enable edge", 4'd3, 16'd54);
        waitc(1);
        rdchk("R7 resumed", 4'd3, 16'd55);
        wr(4'd0, 16'd0);
        wr(4'd3, 16'd7);
        rdchk("R8 write while paused", 4'd3, 16'd7);

        // R9 R10 R11: channels. ch0 compare, ch1 off, ch2 PWM cmp 3, ch3 PWM cmp 7
        wr(4'd8, 16'd5);
        wr(4'd9, 16'd5);
        wr(4'd10, 16'd3);
        wr(4'd11, 16'd7);
        wr(4'd4, 16'h0052);
        rdchk("R12 mode readback", 4'd4, 16'h0052);
        rdchk("R12 cmp3 readback", 4'd11, 16'd7);
        wr(4'd5, 16'h000F);
        setup(16'd0, 16'd9, 16'h0001);
        waitc(4);
        chk("R9 no flag before match", {12'd0, irq_flag}, 16'd0);
        chk("R10 ch2 low at 4", {15'd0, pwm_out[2]}, 16'd0);
        chk("R10 ch3 high at 4", {15'd0, pwm_out[3]}, 16'd1);
        waitc(1);
        chk("R9 ch0 flag on match", {15'd0, irq_flag[0]}, 16'd1);
        chk("R11 off channel no flag", {15'd0, irq_flag[1]}, 16'd0);
        chk("R11 compare output low", {15'd0, pwm_out[0]}, 16'd0);
        wr(4'd5, 16'h0001);
        chk("R9 flag cleared", {15'd0, irq_flag[0]}, 16'd0);
        waitc(9);
        chk("R9 flag sets again", {15'd0, irq_flag[0]}, 16'd1);
        for (int k = 1; k <= 10; k++) begin
            int c;
            c = (5 + k) % 10;
            waitc(1);
            chk($sformatf("R10 ch2 at %0d", c), {15'd0, pwm_out[2]}, 16'(c < 3));
            chk($sformatf("R10 ch3 at %0d", c), {15'd0, pwm_out[3]}, 16'(c < 7));
        end
        waitc(9);
        wr(4'd5, 16'h0001);
        chk("R9 set wins over clear", {15'd0, irq_flag[0]}, 16'd1);
        // R11: switch ch3 off while high, then hold
        wr(4'd4, 16'h0012);
        waitc(3);
        chk("R11 off holds level", {15'd0, pwm_out[3]}, 16'd1);
        // R10: constant levels
        wr(4'd10, 16'd0);
        for (int k = 0; k < 10; k++) begin
            waitc(1);
            chk("R10 cmp zero low", {15'd0, pwm_out[2]}, 16'd0);
        end
        wr(4'd10, 16'd20);
        for (int k = 0; k < 10; k++) begin
            waitc(1);
            chk("R10 cmp above reload high", {15'd0, pwm_out[2]}, 16'd1);
        end

        // R1: reset in mid-run
        rst_n = 1'b0;
        waitc(2);
        rst_n = 1'b1;
        rdchk("R1 count after reset", 4'd3, 16'd0);
        rdchk("R1 cmp after reset", 4'd10, 16'd0);
        chk("R1 flags after reset", {12'd0, irq_flag}, 16'd0);
        waitc(3);
        rdchk("R1 stays stopped", 4'd3, 16'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule